// File: doc/BRIEF.md
# Indirect Management Register Access Engine

This block is a management-bus master. It reaches the register sets inside a multi-device target through two registers that the target exposes at one bus address. Offset 0 holds a command word and offset 1 holds data. A host presents one request at a time: a read or a write, an internal device address, a register address and, for a write, a 16-bit value. The engine builds the command word and runs the bus transactions in order. It polls the busy flag of the command register, waiting a programmable number of cycles between polls and stopping after a bounded number of attempts. It then returns the read data together with a completion status.

When the configured target bus address is zero, the engine does not use the window. It makes one access whose bus address is the requested device address. The serial bit-level shifter lies outside this block. The engine reaches it through a simple port: the engine holds a request high with stable fields, and the port answers with a one-cycle acknowledge that carries read data and an error flag.

Top module: `mgmt_indirect_engine`

## Requirements
- R1: While reset is held and afterwards until a request arrives, `host_ready` is 1 and both `rsp_valid` and `bus_req` are 0.
- R2: Every command word written to offset 0 has bit 15 (busy/start) set and bit 12 (Clause-22 format) set. Bits 11:10 are 2'b10 for a read and 2'b01 for a write. Bits 9:5 carry the device address and bits 4:0 the register address.
- R3: An indirect write runs these steps in order: a busy-wait on offset 0, a write of the data to offset 1, a write of the command to offset 0, and a second busy-wait. It then reports status 2'b00.
- R4: An indirect read runs these steps in order: a busy-wait, a command write to offset 0, a busy-wait, and a read of offset 1. It returns that value on `rsp_rdata` with status 2'b00.
- R5: A poll is a read of offset 0. A poll that returns bit 15 set is followed by exactly `POLL_GAP` cycles with `bus_req` low before the next poll is raised.
- R6: When `MAX_POLLS` consecutive polls in one wait all read busy, the sequence ends with status 2'b01 (timeout) and makes no further bus access.
- R7: When `cfg_target` is 0, a request becomes exactly one bus access, with `bus_addr` equal to the device address and `bus_reg` equal to the register address. A read returns the accessed value.
- R8: An acknowledge that carries `bus_err` ends the sequence on the next cycle with status 2'b10 and makes no further bus access.
- R9: A request is accepted only while `host_ready` is 1. `host_ready` stays 0 from acceptance through the single `rsp_valid` cycle and returns to 1 on the cycle after it.
- R10: While `bus_req` is high and not yet acknowledged, `bus_write`, `bus_addr`, `bus_reg` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_target | input | 5 | Target bus address; 0 selects direct access; captured at acceptance |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Engine idle and able to accept |
| host_write | input | 1 | 1 = write, 0 = read |
| host_dev | input | 5 | Internal device address |
| host_reg | input | 5 | Register address within the device |
| host_wdata | input | 16 | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 ok, 01 timeout, 10 bus error |
| rsp_rdata | output | 16 | Read value (0 for writes and errors) |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_write | output | 1 | Access is a write |
| bus_addr | output | 5 | Bus address of the access |
| bus_reg | output | 5 | Register offset of the access |
| bus_wdata | output | 16 | Value written |
| bus_ack | input | 1 | One-cycle access completion |
| bus_rdata | input | 16 | Read value, valid with `bus_ack` |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |

## Verification
Some rules are local in time, and the assertions check them on every cycle. These are the stability of a pending bus request, the format of each command word written to offset 0, the idle-only acceptance and the ready/response handshake, and the error response that follows a failed acknowledge. The scenarios alone show the rest. That covers the order of the window accesses for reads and writes, the spacing between busy polls, the exact poll count before a timeout, the missing command write after an early error, and the single direct access when the target address is zero. A target model in the bench records each access so that these can be compared.

// File: rtl/mie_pkg.sv
package mie_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 5'd0;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'd1;
    localparam int BUSY_BIT = 15;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_TIMEOUT = 2'b01,
        ST_BUSERR  = 2'b10
    } mie_status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL, S_GAP, S_WDATA, S_WCMD, S_RDATA, S_DIRECT, S_RESP
    } mie_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] dev;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mie_req_t;

    function automatic logic [DATA_W-1:0] mie_cmd_word(
        input logic write, input logic [ADDR_W-1:0] dev, input logic [ADDR_W-1:0] regad);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[15]      = 1'b1;
        w[12]      = 1'b1;
        w[11:10]   = write ? 2'b01 : 2'b10;
        w[9:5]     = dev;
        w[4:0]     = regad;
        return w;
    endfunction
endpackage

// File: rtl/mie_poll_timer.sv
module mie_poll_timer #(
    parameter int MAX_POLLS = 100,
    parameter int POLL_GAP  = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_start,
    input  logic busy_hit,
    output logic last_try,
    output logic gap_done
);
    localparam int RW = $clog2(MAX_POLLS + 1);
    localparam int GW = $clog2(POLL_GAP + 1);

    logic [RW-1:0] retries;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            retries <= '0;
            gap_cnt <= '0;
        end else begin
            if (wait_start)
                retries <= '0;
            else if (busy_hit)
                retries <= retries + 1'b1;

            if (busy_hit)
                gap_cnt <= GW'(POLL_GAP - 1);
            else if (gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assign last_try = (retries == RW'(MAX_POLLS - 1));
    assign gap_done = (gap_cnt == '0);

    // R6
    retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_hit |-> (retries < RW'(MAX_POLLS)));
endmodule

// File: rtl/mie_sequencer.sv
module mie_sequencer
    import mie_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_target,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_dev,
    input  logic [ADDR_W-1:0] host_reg,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] bus_reg,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              wait_start,
    output logic              busy_hit,
    input  logic              last_try,
    input  logic              gap_done
);
    mie_state_e  state;
    mie_req_t    req;
    logic        phase;
    mie_status_e st_q;
    logic [DATA_W-1:0] rd_q;

    logic accept, done_ok;
    assign accept     = host_valid && host_ready;
    assign host_ready = (state == S_IDLE);
    assign done_ok    = bus_ack && !bus_err;
    assign busy_hit   = (state == S_POLL) && done_ok && bus_rdata[BUSY_BIT];
    assign wait_start = (accept && cfg_target != '0) || ((state == S_WCMD) && done_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            req   <= '0;
            phase <= 1'b0;
            st_q  <= ST_OK;
            rd_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (accept) begin
                    req   <= '{write: host_write, tgt: cfg_target, dev: host_dev,
                               regad: host_reg, wdata: host_wdata};
                    phase <= 1'b0;
                    state <= (cfg_target == '0) ? S_DIRECT : S_POLL;
                end
                S_POLL: if (bus_ack) begin
                    if (bus_err) begin
                        state <= S_RESP; st_q <= ST_BUSERR; rd_q <= '0;
                    end else if (bus_rdata[BUSY_BIT]) begin
                        if (last_try) begin
                            state <= S_RESP; st_q <= ST_TIMEOUT; rd_q <= '0;
                        end else begin
                            state <= S_GAP;
                        end
                    end else if (!phase) begin
                        phase <= 1'b1;
                        state <= req.write ? S_WDATA : S_WCMD;
                    end else if (req.write) begin
                        state <= S_RESP; st_q <= ST_OK; rd_q <= '0;
                    end else begin
                        state <= S_RDATA;
                    end
                end
                S_GAP: if (gap_done) state <= S_POLL;
                S_WDATA: if (bus_ack) begin
                    if (bus_err) begin
                        state <= S_RESP; st_q <= ST_BUSERR; rd_q <= '0;
                    end else begin
                        state <= S_WCMD;
                    end
                end
                S_WCMD: if (bus_ack) begin
                    if (bus_err) begin
                        state <= S_RESP; st_q <= ST_BUSERR; rd_q <= '0;
                    end else begin
                        state <= S_POLL;
                    end
                end
                S_RDATA, S_DIRECT: if (bus_ack) begin
                    state <= S_RESP;
                    st_q  <= bus_err ? ST_BUSERR : ST_OK;
                    rd_q  <= (bus_err || (state == S_DIRECT && req.write)) ? '0 : bus_rdata;
                end
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_addr  = req.tgt;
        bus_reg   = OFS_CMD;
        bus_wdata = '0;
        case (state)
            S_POLL:   bus_req = 1'b1;
            S_WDATA:  begin bus_req = 1'b1; bus_write = 1'b1; bus_reg = OFS_DATA; bus_wdata = req.wdata; end
            S_WCMD:   begin bus_req = 1'b1; bus_write = 1'b1;
                            bus_wdata = mie_cmd_word(req.write, req.dev, req.regad); end
            S_RDATA:  begin bus_req = 1'b1; bus_reg = OFS_DATA; end
            S_DIRECT: begin bus_req = 1'b1; bus_write = req.write; bus_addr = req.dev;
                            bus_reg = req.regad; bus_wdata = req.wdata; end
            default:  ;
        endcase
    end

    assign rsp_valid  = (state == S_RESP);
    assign rsp_status = st_q;
    assign rsp_rdata  = rd_q;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_write) && $stable(bus_addr)
                                   && $stable(bus_reg) && $stable(bus_wdata)));
    // R2
    cmd_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_write && state == S_WCMD) |->
        (bus_wdata[15] && bus_wdata[12] && (bus_wdata[11] ^ bus_wdata[10])
         && bus_wdata[11] == !req.write && bus_wdata[9:5] == req.dev && bus_wdata[4:0] == req.regad));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (!bus_req && !rsp_valid));
    // R9
    accept_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready) |=> !host_ready);
    // R9
    rsp_release_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (host_ready && !rsp_valid));
    // R8
    err_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && bus_err) |=> (rsp_valid && rsp_status == 2'b10 && !bus_req));
endmodule

// File: rtl/mgmt_indirect_engine.sv
module mgmt_indirect_engine
    import mie_pkg::*;
#(
    parameter int MAX_POLLS = 100,
    parameter int POLL_GAP  = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  cfg_target,
    input  logic        host_valid,
    output logic        host_ready,
    input  logic        host_write,
    input  logic [4:0]  host_dev,
    input  logic [4:0]  host_reg,
    input  logic [15:0] host_wdata,
    output logic        rsp_valid,
    output logic [1:0]  rsp_status,
    output logic [15:0] rsp_rdata,
    output logic        bus_req,
    output logic        bus_write,
    output logic [4:0]  bus_addr,
    output logic [4:0]  bus_reg,
    output logic [15:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [15:0] bus_rdata,
    input  logic        bus_err
);
    logic wait_start, busy_hit, last_try, gap_done;

    mie_poll_timer #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_timer (
        .clk(clk), .rst(rst), .wait_start(wait_start), .busy_hit(busy_hit),
        .last_try(last_try), .gap_done(gap_done)
    );

    mie_sequencer u_seq (
        .clk(clk), .rst(rst), .cfg_target(cfg_target),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_dev(host_dev), .host_reg(host_reg), .host_wdata(host_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .wait_start(wait_start), .busy_hit(busy_hit), .last_try(last_try), .gap_done(gap_done)
    );
endmodule

// File: tb/mgmt_indirect_engine_tb.sv
module mgmt_indirect_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPOLL = 5;
    localparam int GAP = 4;
    localparam logic [4:0] TGT = 5'd17;

    logic clk = 1'b0, rst = 1'b1;
    logic [4:0] cfg_target = TGT;
    logic host_valid = 1'b0, host_write = 1'b0;
    logic [4:0] host_dev = '0, host_reg = '0;
    logic [15:0] host_wdata = '0;
    logic host_ready, rsp_valid;
    logic [1:0] rsp_status;
    logic [15:0] rsp_rdata;
    logic bus_req, bus_write;
    logic [4:0] bus_addr, bus_reg;
    logic [15:0] bus_wdata;
    logic bus_ack = 1'b0, bus_err = 1'b0;
    logic [15:0] bus_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_indirect_engine #(.MAX_POLLS(NPOLL), .POLL_GAP(GAP)) u_dut (
        .clk(clk), .rst(rst), .cfg_target(cfg_target),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_dev(host_dev), .host_reg(host_reg), .host_wdata(host_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    logic [15:0] imem [0:1023];
    logic [15:0] dmem [0:1023];
    logic [15:0] m_data = '0, last_cmd = '0;
    int busy_left = 0, busy_after = 1, cmd_writes = 0, cyc = 0;
    int log_n = 0, poll_n = 0;
    logic [5:0] log_op [0:63];
    logic [4:0] log_addr [0:63];
    int poll_stamp [0:63];
    bit err_arm = 0, err_wr = 0;
    logic [4:0] err_reg = '0;

    always @(posedge clk) begin
        cyc++;
        if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (log_n < 64) begin
                log_op[log_n] = {bus_write, bus_reg};
                log_addr[log_n] = bus_addr;
                log_n++;
            end
            if (err_arm && bus_write == err_wr && bus_reg == err_reg) begin
                err_arm = 0;
                bus_err <= 1'b1;
                bus_rdata <= '0;
            end else begin
                bus_err <= 1'b0;
                if (bus_addr == TGT) begin
                    if (bus_reg == 5'd0) begin
                        if (bus_write) begin
                            last_cmd = bus_wdata;
                            cmd_writes++;
                            if (bus_wdata[11:10] == 2'b10) m_data = imem[{bus_wdata[9:5], bus_wdata[4:0]}];
                            else if (bus_wdata[11:10] == 2'b01) imem[{bus_wdata[9:5], bus_wdata[4:0]}] = m_data;
                            busy_left = busy_after;
                        end else begin
                            if (poll_n < 64) begin poll_stamp[poll_n] = cyc; poll_n++; end
                            bus_rdata <= (busy_left > 0) ? 16'h8000 : 16'h0000;
                            if (busy_left > 0) busy_left--;
                        end
                    end else if (bus_reg == 5'd1) begin
                        if (bus_write) m_data = bus_wdata;
                        else bus_rdata <= m_data;
                    end
                end else begin
                    if (bus_write) dmem[{bus_addr, bus_reg}] = bus_wdata;
                    else bus_rdata <= dmem[{bus_addr, bus_reg}];
                end
            end
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic [1:0] st; logic [15:0] rd; string tag; } exp_t;
    exp_t exp_q [$];

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_status == e.st, {e.tag, " status"}, rsp_status, e.st);
                chk(rsp_rdata == e.rd, {e.tag, " rdata"}, rsp_rdata, e.rd);
            end
        end
    end

    task automatic clear_log();
        log_n = 0; poll_n = 0;
    endtask

    task automatic do_req(input bit w, input logic [4:0] dev, input logic [4:0] rg,
                          input logic [15:0] wd, input logic [1:0] est, input logic [15:0] erd,
                          input string tag);
        exp_t e;
        e.st = est; e.rd = erd; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_write = w; host_dev = dev; host_reg = rg; host_wdata = wd;
        @(negedge clk);
        host_valid = 1'b0;
        chk(host_ready == 1'b0, {tag, " R9 ready low in sequence"}, host_ready, 0);
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
        chk(host_ready == 1'b1, {tag, " R9 ready back"}, host_ready, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            imem[i] = 16'hA000 + 16'(i);
            dmem[i] = 16'h5000 + 16'(i);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(host_ready == 1'b1, "R1 ready in reset", host_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        chk(bus_req == 1'b0, "R1 bus_req in reset", bus_req, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(host_ready == 1'b1 && bus_req == 1'b0, "R1 idle after reset", bus_req, 0);

        // R3 indirect write and R2 command word
        clear_log();
        do_req(1, 5'd3, 5'd7, 16'hBEEF, 2'b00, 16'h0, "R3 write");
        chk(last_cmd == 16'h9467, "R2 write command word", last_cmd, 16'h9467);
        chk(log_op[0] == 6'h00, "R3 first step poll", log_op[0], 6'h00);
        chk(log_op[1] == 6'h21, "R3 second step data write", log_op[1], 6'h21);
        chk(log_op[2] == 6'h20, "R3 third step command write", log_op[2], 6'h20);
        chk(log_op[3] == 6'h00 && log_n == 5, "R3 trailing polls", log_n, 5);

        // R4 indirect read back
        clear_log();
        do_req(0, 5'd3, 5'd7, 16'h0, 2'b00, 16'hBEEF, "R4 read back");
        chk(last_cmd == 16'h9867, "R2 read command word", last_cmd, 16'h9867);
        chk(log_op[1] == 6'h20 && log_op[log_n-1] == 6'h01, "R4 step order", log_op[log_n-1], 6'h01);

        // R5 poll spacing with busy at start
        clear_log();
        busy_left = 2;
        do_req(0, 5'd4, 5'd1, 16'h0, 2'b00, 16'hA081, "R5 read with busy");
        chk(poll_stamp[1] - poll_stamp[0] == GAP + 2, "R5 poll spacing", poll_stamp[1] - poll_stamp[0], GAP + 2);
        chk(poll_stamp[2] - poll_stamp[1] == GAP + 2, "R5 poll spacing 2", poll_stamp[2] - poll_stamp[1], GAP + 2);

        // R6 timeout
        clear_log();
        busy_left = 1000;
        begin
            int cw;
            cw = cmd_writes;
            do_req(0, 5'd2, 5'd2, 16'h0, 2'b01, 16'h0, "R6 timeout");
            chk(poll_n == NPOLL, "R6 poll count", poll_n, NPOLL);
            chk(cmd_writes == cw && log_n == NPOLL, "R6 no further access", log_n, NPOLL);
        end
        busy_left = 0;

        // R8 error on data write
        clear_log();
        err_arm = 1; err_wr = 1; err_reg = 5'd1;
        begin
            int cw;
            cw = cmd_writes;
            do_req(1, 5'd6, 5'd6, 16'h7777, 2'b10, 16'h0, "R8 data write error");
            chk(cmd_writes == cw && log_n == 2, "R8 sequence stopped", log_n, 2);
        end
        // R8 error on poll during read
        clear_log();
        err_arm = 1; err_wr = 0; err_reg = 5'd0;
        do_req(0, 5'd6, 5'd6, 16'h0, 2'b10, 16'h0, "R8 poll error");
        chk(log_n == 1, "R8 single access", log_n, 1);

        // R7 direct mode
        cfg_target = 5'd0;
        clear_log();
        begin
            int cw;
            cw = cmd_writes;
            do_req(1, 5'd9, 5'd2, 16'h1234, 2'b00, 16'h0, "R7 direct write");
            chk(log_n == 1 && log_addr[0] == 5'd9 && log_op[0] == 6'h22, "R7 direct write access", log_op[0], 6'h22);
            clear_log();
            do_req(0, 5'd9, 5'd2, 16'h0, 2'b00, 16'h1234, "R7 direct read");
            chk(log_n == 1 && log_op[0] == 6'h02, "R7 direct read access", log_op[0], 6'h02);
            do_req(0, 5'd10, 5'd3, 16'h0, 2'b00, 16'h5143, "R7 direct preset read");
            chk(cmd_writes == cw, "R7 no command writes", cmd_writes, cw);
        end
        cfg_target = TGT;

        // R10 write after direct, back in indirect
        do_req(1, 5'd31, 5'd31, 16'h0F0F, 2'b00, 16'h0, "R10 indirect write edge addr");
        chk(last_cmd == 16'h97FF, "R2 max address command word", last_cmd, 16'h97FF);
        do_req(0, 5'd31, 5'd31, 16'h0, 2'b00, 16'h0F0F, "R4 edge read");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule